// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block updates the exception state of a small processor core when an exception is raised. There are two request channels. A general exception supplies the faulting PC, a cause code and, optionally, a faulting virtual address. A debug exception supplies the PC and a debug cause. Both channels act on the current processor status word, which the core presents on `ps_i`.

For a general exception, the block chooses one of three vectors: kernel, user or double. The exception-mode and user-mode bits of the status word decide which one. A debug exception is taken only when the current interrupt level is below the configured debug level. When it is taken, the block saves the PC and the old status word into the registers for that level.

All register updates happen on the clock edge that accepts a request. A one-cycle acknowledge follows on the matching channel. The vector code and the new status word are held on the outputs for the core to pick up. Vector fetch, pipeline flush and decode belong to the core.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, both acknowledges are low, `vec_o` is 0 (none), and every saved register and `ps_o` read zero.
- R2: A general request is accepted with `ps_i` exception-mode bit (bit 4) and user-mode bit (bit 5) both clear. One cycle later `gen_ack_o` is high, `vec_o` is 1 (kernel) and `epc1_o` holds the request PC.
- R3: A general request is accepted with bit 4 clear and bit 5 set. The result is `vec_o` 2 (user), with the PC saved in `epc1_o`.
- R4: A general request is accepted with bit 4 set. The result is `vec_o` 3 (double), with the PC saved in `depc_o` when HAS_DEPC is 1, and in `epc1_o` otherwise; the other one of the two is left unchanged.
- R5: Every accepted general request loads the cause into `exccause_o`. It also sets `ps_o` to `ps_i` with bit 4 set and every other bit unchanged, and leaves the debug registers untouched.
- R6: `excvaddr_o` takes the request address only when `gen_has_vaddr_i` is high. Otherwise it keeps its value.
- R7: A debug request is accepted while the interrupt-level field (`ps_i[3:0]`) is strictly below DEBUG_LEVEL. One cycle later `dbg_ack_o` is high and `vec_o` is 4 (debug). `epc_dbg_o` holds the PC, `eps_dbg_o` holds the old `ps_i`, and `dbgcause_o` holds the cause. `ps_o` equals `ps_i` with bits [3:0] set to DEBUG_LEVEL and bit 4 set. The general registers are unchanged.
- R8: A debug request is accepted while the level field is DEBUG_LEVEL or above. It is acknowledged with `vec_o` 0 (none), and no register or `ps_o` changes.
- R9: When both requests are pending in the same cycle, the debug request is served first. The general request is acknowledged on the following cycle. The two acknowledges are never high together.
- R10: Each acknowledge is a single-cycle pulse. A request that is still held high while its acknowledge is high is not accepted a second time in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gen_req_i | input | 1 | General exception request, held until acknowledged |
| gen_pc_i | input | XLEN | Faulting PC of the general exception |
| gen_cause_i | input | CAUSE_W | General cause code |
| gen_has_vaddr_i | input | 1 | Request carries a faulting virtual address |
| gen_vaddr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request, held until acknowledged |
| dbg_pc_i | input | XLEN | PC of the debug exception |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| ps_i | input | PS_W | Current processor status word |
| gen_ack_o | output | 1 | General request accepted (one-cycle pulse) |
| dbg_ack_o | output | 1 | Debug request accepted (one-cycle pulse) |
| vec_o | output | 3 | Vector of the last accepted request: 0 none, 1 kernel, 2 user, 3 double, 4 debug |
| ps_o | output | PS_W | Updated status word for the core to load |
| epc1_o | output | XLEN | Level-1 saved PC |
| depc_o | output | XLEN | Double-exception saved PC |
| epc_dbg_o | output | XLEN | Saved PC for the debug level |
| eps_dbg_o | output | PS_W | Saved status word for the debug level |
| exccause_o | output | CAUSE_W | General cause register |
| excvaddr_o | output | XLEN | Faulting virtual address register |
| dbgcause_o | output | DCAUSE_W | Debug cause register |

## Verification
The bench sweeps every combination of the interrupt-level field and the exception-mode and user-mode bits, on both channels. This includes the boundary where the level equals DEBUG_LEVEL. A design that compares with less-or-equal would take a debug exception it must ignore. A design that ignores the mode bits would pick the wrong vector.

On double exceptions, the bench checks that the level-1 PC survives. A design that always writes `epc1_o` would lose the first fault's PC. It also checks that requests without an address leave `excvaddr_o` alone, and that upper status bits pass through untouched.

Simultaneous requests, with the debug level both eligible and ineligible, expose a design that serves general first, drops the held-off request, or acknowledges twice.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    VEC_NONE   = 3'd0,
    VEC_KERNEL = 3'd1,
    VEC_USER   = 3'd2,
    VEC_DOUBLE = 3'd3,
    VEC_DEBUG  = 3'd4
  } exc_vec_e;

  localparam int unsigned VEC_W = 3;

endpackage

// File: rtl/exc_gen_path.sv
module exc_gen_path
  import exc_entry_pkg::*;
#(
  parameter int unsigned PS_W     = 32,
  parameter int unsigned EXCM_BIT = 4,
  parameter int unsigned UM_BIT   = 5,
  parameter bit          HAS_DEPC = 1'b1
) (
  input  logic [PS_W-1:0] ps_i,
  output exc_vec_e        vec_o,
  output logic            to_depc_o,
  output logic [PS_W-1:0] ps_new_o
);

  localparam logic [PS_W-1:0] EXCM_MASK = PS_W'(1) << EXCM_BIT;

  always_comb begin
    if (ps_i[EXCM_BIT]) begin
      vec_o     = VEC_DOUBLE;
      to_depc_o = HAS_DEPC;
    end else begin
      vec_o     = ps_i[UM_BIT] ? VEC_USER : VEC_KERNEL;
      to_depc_o = 1'b0;
    end
    ps_new_o = ps_i | EXCM_MASK;
  end

endmodule

// File: rtl/exc_dbg_path.sv
module exc_dbg_path #(
  parameter int unsigned PS_W        = 32,
  parameter int unsigned IL_LSB      = 0,
  parameter int unsigned IL_W        = 4,
  parameter int unsigned EXCM_BIT    = 4,
  parameter int unsigned DEBUG_LEVEL = 6
) (
  input  logic [PS_W-1:0] ps_i,
  output logic            take_o,
  output logic [PS_W-1:0] ps_new_o
);

  localparam logic [IL_W-1:0] DBG_LVL   = IL_W'(DEBUG_LEVEL);
  localparam logic [PS_W-1:0] IL_MASK   = ((PS_W'(1) << IL_W) - PS_W'(1)) << IL_LSB;
  localparam logic [PS_W-1:0] EXCM_MASK = PS_W'(1) << EXCM_BIT;

  logic [IL_W-1:0] cur_lvl;

  always_comb begin
    cur_lvl  = ps_i[IL_LSB +: IL_W];
    take_o   = cur_lvl < DBG_LVL;
    ps_new_o = (ps_i & ~IL_MASK) | (PS_W'(DBG_LVL) << IL_LSB) | EXCM_MASK;
  end

endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned DCAUSE_W = 6,
  parameter int unsigned PS_W     = 32,
  parameter bit          HAS_DEPC = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                epc1_we_i,
  input  logic                depc_we_i,
  input  logic                cause_we_i,
  input  logic                vaddr_we_i,
  input  logic                dbg_we_i,
  input  logic                ps_we_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [XLEN-1:0]     vaddr_i,
  input  logic [DCAUSE_W-1:0] dcause_i,
  input  logic [PS_W-1:0]     ps_old_i,
  input  logic [PS_W-1:0]     ps_new_i,
  output logic [XLEN-1:0]     epc1_o,
  output logic [XLEN-1:0]     depc_o,
  output logic [XLEN-1:0]     epc_dbg_o,
  output logic [PS_W-1:0]     eps_dbg_o,
  output logic [CAUSE_W-1:0]  exccause_o,
  output logic [XLEN-1:0]     excvaddr_o,
  output logic [DCAUSE_W-1:0] dbgcause_o,
  output logic [PS_W-1:0]     ps_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc1_o     <= '0;
      exccause_o <= '0;
      excvaddr_o <= '0;
    end else begin
      if (epc1_we_i)  epc1_o     <= pc_i;
      if (cause_we_i) exccause_o <= cause_i;
      if (vaddr_we_i) excvaddr_o <= vaddr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_dbg_o  <= '0;
      eps_dbg_o  <= '0;
      dbgcause_o <= '0;
    end else if (dbg_we_i) begin
      epc_dbg_o  <= pc_i;
      eps_dbg_o  <= ps_old_i;
      dbgcause_o <= dcause_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ps_o <= '0;
    else if (ps_we_i) ps_o <= ps_new_i;
  end

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        depc_q <= '0;
        else if (depc_we_i) depc_q <= pc_i;
      end
      assign depc_o = depc_q;
    end else begin : g_no_depc
      assign depc_o = '0;
    end
  endgenerate

  // R5 / R7: general and debug saves never share a cycle
  a_r5_no_mixed_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dbg_we_i && (cause_we_i || epc1_we_i || depc_we_i)));

  // R6: address register moves only under its own enable
  a_r6_vaddr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vaddr_we_i |=> $stable(excvaddr_o));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned CAUSE_W     = 6,
  parameter int unsigned DCAUSE_W    = 6,
  parameter int unsigned PS_W        = 32,
  parameter int unsigned IL_LSB      = 0,
  parameter int unsigned IL_W        = 4,
  parameter int unsigned EXCM_BIT    = 4,
  parameter int unsigned UM_BIT      = 5,
  parameter int unsigned DEBUG_LEVEL = 6,
  parameter bit          HAS_DEPC    = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gen_req_i,
  input  logic [XLEN-1:0]     gen_pc_i,
  input  logic [CAUSE_W-1:0]  gen_cause_i,
  input  logic                gen_has_vaddr_i,
  input  logic [XLEN-1:0]     gen_vaddr_i,
  input  logic                dbg_req_i,
  input  logic [XLEN-1:0]     dbg_pc_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic [PS_W-1:0]     ps_i,
  output logic                gen_ack_o,
  output logic                dbg_ack_o,
  output logic [2:0]          vec_o,
  output logic [PS_W-1:0]     ps_o,
  output logic [XLEN-1:0]     epc1_o,
  output logic [XLEN-1:0]     depc_o,
  output logic [XLEN-1:0]     epc_dbg_o,
  output logic [PS_W-1:0]     eps_dbg_o,
  output logic [CAUSE_W-1:0]  exccause_o,
  output logic [XLEN-1:0]     excvaddr_o,
  output logic [DCAUSE_W-1:0] dbgcause_o
);

  exc_vec_e        gen_vec;
  logic            gen_to_depc;
  logic [PS_W-1:0] gen_ps_new;
  logic            dbg_take;
  logic [PS_W-1:0] dbg_ps_new;
  logic            dbg_fire, gen_fire, dbg_commit;
  logic            gen_ack_q, dbg_ack_q;
  exc_vec_e        vec_q;

  exc_gen_path #(
    .PS_W(PS_W), .EXCM_BIT(EXCM_BIT), .UM_BIT(UM_BIT), .HAS_DEPC(HAS_DEPC)
  ) u_gen (
    .ps_i(ps_i), .vec_o(gen_vec), .to_depc_o(gen_to_depc), .ps_new_o(gen_ps_new)
  );

  exc_dbg_path #(
    .PS_W(PS_W), .IL_LSB(IL_LSB), .IL_W(IL_W), .EXCM_BIT(EXCM_BIT),
    .DEBUG_LEVEL(DEBUG_LEVEL)
  ) u_dbg (
    .ps_i(ps_i), .take_o(dbg_take), .ps_new_o(dbg_ps_new)
  );

  // debug wins the cycle even when it is dropped; general waits one cycle
  assign dbg_fire   = dbg_req_i && !dbg_ack_q;
  assign gen_fire   = gen_req_i && !gen_ack_q && !dbg_fire;
  assign dbg_commit = dbg_fire && dbg_take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_ack_q <= 1'b0;
      dbg_ack_q <= 1'b0;
      vec_q     <= VEC_NONE;
    end else begin
      gen_ack_q <= gen_fire;
      dbg_ack_q <= dbg_fire;
      if (dbg_fire)      vec_q <= dbg_take ? VEC_DEBUG : VEC_NONE;
      else if (gen_fire) vec_q <= gen_vec;
    end
  end

  exc_sreg_file #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .PS_W(PS_W),
    .HAS_DEPC(HAS_DEPC)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .epc1_we_i  (gen_fire && !gen_to_depc),
    .depc_we_i  (gen_fire && gen_to_depc),
    .cause_we_i (gen_fire),
    .vaddr_we_i (gen_fire && gen_has_vaddr_i),
    .dbg_we_i   (dbg_commit),
    .ps_we_i    (gen_fire || dbg_commit),
    .pc_i       (dbg_fire ? dbg_pc_i : gen_pc_i),
    .cause_i    (gen_cause_i),
    .vaddr_i    (gen_vaddr_i),
    .dcause_i   (dbg_cause_i),
    .ps_old_i   (ps_i),
    .ps_new_i   (dbg_fire ? dbg_ps_new : gen_ps_new),
    .epc1_o     (epc1_o),
    .depc_o     (depc_o),
    .epc_dbg_o  (epc_dbg_o),
    .eps_dbg_o  (eps_dbg_o),
    .exccause_o (exccause_o),
    .excvaddr_o (excvaddr_o),
    .dbgcause_o (dbgcause_o),
    .ps_o       (ps_o)
  );

  assign gen_ack_o = gen_ack_q;
  assign dbg_ack_o = dbg_ack_q;
  assign vec_o     = vec_q;

  logic gen_alone;
  assign gen_alone = gen_req_i && !gen_ack_o && !(dbg_req_i && !dbg_ack_o);

  a_r2_kernel_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_alone && !ps_i[EXCM_BIT] && !ps_i[UM_BIT])
      |=> (gen_ack_o && vec_o == 3'd1 && epc1_o == $past(gen_pc_i)));

  a_r3_user_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_alone && !ps_i[EXCM_BIT] && ps_i[UM_BIT]) |=> (gen_ack_o && vec_o == 3'd2));

  a_r4_double_keeps_epc1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_alone && ps_i[EXCM_BIT] && HAS_DEPC)
      |=> (vec_o == 3'd3 && $stable(epc1_o) && depc_o == $past(gen_pc_i)));

  a_r5_excm_after_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_ack_o |-> ps_o[EXCM_BIT]);

  a_r7_debug_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ack_o && vec_o == 3'd4) |-> (ps_o[IL_LSB +: IL_W] == IL_W'(DEBUG_LEVEL)
                                      && ps_o[EXCM_BIT]));

  a_r8_dropped_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ack_o && vec_o == 3'd0) |-> ($stable(ps_o) && $stable(epc_dbg_o)
                                      && $stable(eps_dbg_o)));

  a_r9_debug_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && gen_req_i && !dbg_ack_o && !gen_ack_o) |=> (dbg_ack_o && !gen_ack_o));

  a_r9_one_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gen_ack_o && dbg_ack_o));

  a_r10_gen_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_ack_o |=> !gen_ack_o);

  a_r10_dbg_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_ack_o |=> !dbg_ack_o);

endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

  localparam int DLVL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_req = 1'b0, gen_hv = 1'b0, dbg_req = 1'b0;
  logic [31:0] gen_pc = '0, gen_va = '0, dbg_pc = '0, ps = '0;
  logic [5:0]  gen_cause = '0, dbg_cause = '0;
  logic        gen_ack, dbg_ack;
  logic [2:0]  vec;
  logic [31:0] ps_o, epc1, depc, epcd, epsd, vaddr;
  logic [5:0]  cause, dcause;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_epc1 = 0, m_depc = 0, m_epcd = 0, m_epsd = 0, m_vaddr = 0, m_ps = 0;
  logic [5:0]  m_cause = 0, m_dcause = 0;
  logic [2:0]  m_vec = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .gen_req_i(gen_req), .gen_pc_i(gen_pc), .gen_cause_i(gen_cause),
    .gen_has_vaddr_i(gen_hv), .gen_vaddr_i(gen_va),
    .dbg_req_i(dbg_req), .dbg_pc_i(dbg_pc), .dbg_cause_i(dbg_cause),
    .ps_i(ps),
    .gen_ack_o(gen_ack), .dbg_ack_o(dbg_ack), .vec_o(vec), .ps_o(ps_o),
    .epc1_o(epc1), .depc_o(depc), .epc_dbg_o(epcd), .eps_dbg_o(epsd),
    .exccause_o(cause), .excvaddr_o(vaddr), .dbgcause_o(dcause)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(vec == m_vec, {req, " vec"}, 32'(vec), 32'(m_vec));
    chk(ps_o == m_ps, {req, " ps"}, ps_o, m_ps);
    chk(epc1 == m_epc1, {req, " epc1"}, epc1, m_epc1);
    chk(depc == m_depc, {req, " depc"}, depc, m_depc);
    chk(epcd == m_epcd, {req, " epc_dbg"}, epcd, m_epcd);
    chk(epsd == m_epsd, {req, " eps_dbg"}, epsd, m_epsd);
    chk(cause == m_cause, {req, " cause"}, 32'(cause), 32'(m_cause));
    chk(vaddr == m_vaddr, {req, " vaddr"}, vaddr, m_vaddr);
    chk(dcause == m_dcause, {req, " dcause"}, 32'(dcause), 32'(m_dcause));
  endtask

  function automatic string gen_tag(input logic [31:0] p);
    if (p[4]) return "R4";
    return p[5] ? "R3" : "R2";
  endfunction

  task automatic model_gen(input logic [31:0] p, input logic [31:0] pc,
                           input logic [5:0] c, input bit hv, input logic [31:0] va);
    if (p[4]) begin m_vec = 3; m_depc = pc; end
    else begin m_vec = p[5] ? 3'd2 : 3'd1; m_epc1 = pc; end
    m_cause = c;
    if (hv) m_vaddr = va;
    m_ps = p | 32'h10;
  endtask

  task automatic model_dbg(input logic [31:0] p, input logic [31:0] pc, input logic [5:0] c);
    if (p[3:0] < DLVL) begin
      m_vec = 4; m_epcd = pc; m_epsd = p; m_dcause = c;
      m_ps = (p & ~32'hF) | 32'(DLVL) | 32'h10;
    end else m_vec = 0;
  endtask

  task automatic gen_txn(input logic [31:0] p, input logic [31:0] pc,
                         input logic [5:0] c, input bit hv, input logic [31:0] va);
    @(negedge clk);
    ps = p; gen_pc = pc; gen_cause = c; gen_hv = hv; gen_va = va; gen_req = 1'b1;
    @(negedge clk);
    model_gen(p, pc, c, hv, va);
    chk(gen_ack == 1'b1, {gen_tag(p), " R5 ack"}, 32'(gen_ack), 1);
    chk_regs(hv ? {gen_tag(p), " R5 R6"} : {gen_tag(p), " R5 R6 no-addr"});
    gen_req = 1'b0;
    @(negedge clk);
    chk(gen_ack == 1'b0, "R10 gen ack drop", 32'(gen_ack), 0);
  endtask

  task automatic dbg_txn(input logic [31:0] p, input logic [31:0] pc, input logic [5:0] c);
    @(negedge clk);
    ps = p; dbg_pc = pc; dbg_cause = c; dbg_req = 1'b1;
    @(negedge clk);
    model_dbg(p, pc, c);
    chk(dbg_ack == 1'b1, "R7 R8 dbg ack", 32'(dbg_ack), 1);
    chk_regs(p[3:0] < DLVL ? "R7" : "R8");
    dbg_req = 1'b0;
    @(negedge clk);
    chk(dbg_ack == 1'b0, "R10 dbg ack drop", 32'(dbg_ack), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gen_ack == 0 && dbg_ack == 0, "R1 acks", {30'd0, gen_ack, dbg_ack}, 0);
    chk_regs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_regs("R1 after release");

    // full sweep of level, mode and user bits on both channels
    for (int k = 0; k < 64; k++) begin
      logic [31:0] p;
      p = 32'h5A00_0000 | (32'(k) << 8) | 32'(k);
      gen_txn(p, 32'h1000_0000 + 32'(k) * 4, 6'(k), 1'b1, 32'hC000_0000 ^ 32'(k * 977));
      gen_txn(p, 32'h2000_0000 + 32'(k) * 8, 6'(63 - k), 1'b0, 32'hDEAD_0000 + 32'(k));
      dbg_txn(p, 32'h3000_0000 + 32'(k) * 16, 6'(k ^ 21));
    end

    // R4: double exception keeps level-1 PC from an earlier fault
    gen_txn(32'h0, 32'h4444_0000, 6'd9, 1'b1, 32'h1234_5678);
    gen_txn(32'h10, 32'h5555_0000, 6'd11, 1'b0, 32'h0);
    chk(epc1 == 32'h4444_0000, "R4 epc1 kept", epc1, 32'h4444_0000);

    // R10: request held through its ack is not taken twice
    @(negedge clk);
    ps = 32'h0; gen_pc = 32'h6666_0000; gen_cause = 6'd3; gen_hv = 1'b0; gen_req = 1'b1;
    @(negedge clk);
    model_gen(32'h0, 32'h6666_0000, 6'd3, 1'b0, 32'h0);
    chk(gen_ack == 1'b1, "R10 first ack", 32'(gen_ack), 1);
    @(negedge clk);
    chk(gen_ack == 1'b0, "R10 no second ack", 32'(gen_ack), 0);
    gen_req = 1'b0;
    @(negedge clk);
    chk_regs("R10");

    // R9: simultaneous, debug eligible then ineligible
    for (int t = 0; t < 2; t++) begin
      logic [31:0] p;
      p = (t == 0) ? 32'h0000_0022 : 32'h0000_0027;
      @(negedge clk);
      ps = p;
      gen_pc = 32'h7000_0000 + 32'(t); gen_cause = 6'(40 + t); gen_hv = 1'b1;
      gen_va = 32'h8800_0000 + 32'(t);
      dbg_pc = 32'h7700_0000 + 32'(t); dbg_cause = 6'(50 + t);
      gen_req = 1'b1; dbg_req = 1'b1;
      @(negedge clk);
      model_dbg(p, 32'h7700_0000 + 32'(t), 6'(50 + t));
      chk(dbg_ack == 1'b1, "R9 debug first", 32'(dbg_ack), 1);
      chk(gen_ack == 1'b0, "R9 general held", 32'(gen_ack), 0);
      chk_regs("R9 debug stage");
      dbg_req = 1'b0;
      @(negedge clk);
      model_gen(p, 32'h7000_0000 + 32'(t), 6'(40 + t), 1'b1, 32'h8800_0000 + 32'(t));
      chk(gen_ack == 1'b1, "R9 general next", 32'(gen_ack), 1);
      chk(dbg_ack == 1'b0, "R9 one ack", 32'(dbg_ack), 0);
      chk_regs("R9 general stage");
      gen_req = 1'b0;
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule